// File: doc/BRIEF.md
# TDM Frame Boundary Detector

This block recovers the frame alignment of a time-division-multiplexed serial bus. It watches the bus bit clock and the frame pulse and oversamples both with a faster system clock. From them it produces a one-cycle frame-start strobe and a bit counter that is aligned to the frame. Downstream serial capture and switching logic use the counter to know which bit of the frame is on the wire.

Three static controls set how the frame pulse is read. The bus convention selects the pulse's active level. The width setting selects a one-period or a two-period pulse. The clock polarity setting selects the bus clock edge that marks bit times, called the reference edge. A pulse counts as a frame marker only if it holds exactly the expected number of reference edges. The last reference edge inside a valid pulse is the frame boundary. A pulse of the wrong width sets a sticky error flag and leaves the counter alone.

Top module: `tdm_frame_boundary`

## Requirements
- R1: While reset is held, `frame_start_o`, `bit_count_o` and `width_err_o` are all zero.
- R2: With `gci_mode_i` = 0 the frame pulse is active when low. With `gci_mode_i` = 1 it is active when high.
- R3: The reference edge is the rising edge of `bus_clk_i` when `clk_invert_i` = 0 and the falling edge when it is 1. `bit_count_o` advances by one on each reference edge and wraps from FRAME_BITS-1 to 0.
- R4: With `wide_pulse_i` = 0 a valid pulse holds exactly one reference edge while active. With `wide_pulse_i` = 1 it holds exactly two.
- R5: When a valid pulse ends, `frame_start_o` is high for exactly one system clock and `bit_count_o` is zero in that cycle. Reading `bit_count_o` after a boundary therefore gives the number of reference edges since the boundary edge, modulo FRAME_BITS.
- R6: When a pulse ends holding the wrong number of reference edges, no strobe is produced and the counter keeps its phase. `width_err_o` rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Bus bit clock, asynchronous to `clk` |
| frame_pulse_i | input | 1 | Frame pulse, asynchronous to `clk` |
| gci_mode_i | input | 1 | Bus convention: 0 = active-low pulse, 1 = active-high pulse |
| wide_pulse_i | input | 1 | Pulse width: 0 = one bus clock period, 1 = two |
| clk_invert_i | input | 1 | 0 = rising reference edge, 1 = falling reference edge |
| frame_start_o | output | 1 | One-cycle strobe at each qualified frame boundary |
| bit_count_o | output | $clog2(FRAME_BITS) | Reference edges counted since the last boundary |
| width_err_o | output | 1 | Sticky flag for a pulse of the wrong width |

## Verification
The assertions assume the three configuration inputs stay fixed between resets. They also assume each bus clock half-period lasts several system clocks, so every edge survives the two-flop synchronizer as a separate sample. The stimulus builds each bit slot from eight system clocks and changes the pulse only on the edge opposite the reference edge, so the pulse never moves at the same instant as the edge being counted. The configuration is changed only while reset is held.

// File: rtl/tdm_fb_pkg.sv
package tdm_fb_pkg;

  typedef enum logic {
    PULSE_ACT_LOW  = 1'b0,
    PULSE_ACT_HIGH = 1'b1
  } pulse_level_e;

  localparam int EDGE_CNT_W = 2;

  // reference edges a valid pulse must contain
  function automatic logic [EDGE_CNT_W-1:0] edges_expected(input logic wide);
    return wide ? EDGE_CNT_W'(2) : EDGE_CNT_W'(1);
  endfunction

endpackage

// File: rtl/tdm_fb_sync.sv
module tdm_fb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/tdm_fb_qualify.sv
module tdm_fb_qualify
  import tdm_fb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_s,
  input  logic pulse_s,
  input  logic gci_i,
  input  logic wide_i,
  input  logic invert_i,
  output logic ref_edge_o,
  output logic boundary_o,
  output logic err_o
);

  localparam int ARM_W = SYNC_STAGES + 1;

  logic                  clk_d;
  logic                  act_d;
  logic                  err_q;
  logic [ARM_W-1:0]      arm_sh;
  logic [EDGE_CNT_W-1:0] edge_cnt;
  logic                  armed, act, rise, fall, pulse_end, match, bad;

  assign armed      = arm_sh[ARM_W-1];
  assign act        = (pulse_level_e'(gci_i) == PULSE_ACT_HIGH) ? pulse_s : ~pulse_s;
  assign rise       = ~clk_d & bus_clk_s;
  assign fall       = clk_d & ~bus_clk_s;
  assign ref_edge_o = armed & (invert_i ? fall : rise);
  assign pulse_end  = act_d & ~act;
  assign match      = (edge_cnt == edges_expected(wide_i));
  assign boundary_o = pulse_end & match;
  assign bad        = pulse_end & ~match;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_sh   <= '0;
      clk_d    <= 1'b0;
      act_d    <= 1'b0;
      edge_cnt <= '0;
      err_q    <= 1'b0;
    end else begin
      arm_sh <= {arm_sh[ARM_W-2:0], 1'b1};
      clk_d  <= bus_clk_s;
      act_d  <= armed & act;
      if (pulse_end)
        edge_cnt <= '0;
      else if (act && ref_edge_o && edge_cnt != '1)
        edge_cnt <= edge_cnt + EDGE_CNT_W'(1);
      if (bad) err_q <= 1'b1;
    end
  end

  // R6: error flag never clears outside reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R4: the width count is cleared after every pulse end
  assert_cnt_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    pulse_end |=> (edge_cnt <= EDGE_CNT_W'(1)));

endmodule

// File: rtl/tdm_fb_counter.sv
module tdm_fb_counter #(
  parameter int FRAME_BITS = 1024,
  parameter int CW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_edge_i,
  input  logic          boundary_i,
  output logic [CW-1:0] count_o,
  output logic          start_o
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] count_q;
  logic          start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= boundary_i;
      if (boundary_i)
        count_q <= '0;
      else if (ref_edge_i)
        count_q <= (count_q == LAST) ? '0 : count_q + CW'(1);
    end
  end

  assign count_o = count_q;
  assign start_o = start_q;

  // R3: counter only steps by one or returns to zero
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(count_q) |-> (count_q == '0 || count_q == $past(count_q) + CW'(1)));

  // R3: counter stays inside the frame
  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST);

  // R5: strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R5: counter is zero while the strobe is high
  assert_start_zero_R5: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (count_q == '0));

endmodule

// File: rtl/tdm_frame_boundary.sv
module tdm_frame_boundary #(
  parameter  int FRAME_BITS  = 1024,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_clk_i,
  input  logic          frame_pulse_i,
  input  logic          gci_mode_i,
  input  logic          wide_pulse_i,
  input  logic          clk_invert_i,
  output logic          frame_start_o,
  output logic [CW-1:0] bit_count_o,
  output logic          width_err_o
);

  logic [1:0] sync_q;
  logic       ref_edge, boundary;

  tdm_fb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({frame_pulse_i, bus_clk_i}),
    .q_o (sync_q)
  );

  tdm_fb_qualify #(.SYNC_STAGES(SYNC_STAGES)) u_qualify (
    .clk        (clk),
    .rst        (rst),
    .bus_clk_s  (sync_q[0]),
    .pulse_s    (sync_q[1]),
    .gci_i      (gci_mode_i),
    .wide_i     (wide_pulse_i),
    .invert_i   (clk_invert_i),
    .ref_edge_o (ref_edge),
    .boundary_o (boundary),
    .err_o      (width_err_o)
  );

  tdm_fb_counter #(.FRAME_BITS(FRAME_BITS), .CW(CW)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .ref_edge_i (ref_edge),
    .boundary_i (boundary),
    .count_o    (bit_count_o),
    .start_o    (frame_start_o)
  );

  // R6: a rejected pulse never coincides with a strobe
  assert_no_start_on_err_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(width_err_o) |-> !frame_start_o);

endmodule

// File: tb/tdm_frame_boundary_bench.sv
`timescale 1ns/1ps
module tdm_frame_boundary_bench;

  localparam int F  = 16;
  localparam int CW = $clog2(F);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_clk = 1'b0, fp = 1'b1, gci = 1'b0, wide = 1'b0, inv = 1'b0;
  logic          fs, err;
  logic [CW-1:0] cnt;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tdm_frame_boundary #(.FRAME_BITS(F)) u_tdm_frame_boundary (
    .clk           (clk),
    .rst           (rst),
    .bus_clk_i     (bus_clk),
    .frame_pulse_i (fp),
    .gci_mode_i    (gci),
    .wide_pulse_i  (wide),
    .clk_invert_i  (inv),
    .frame_start_o (fs),
    .bit_count_o   (cnt),
    .width_err_o   (err)
  );

  always @(negedge clk) if (!rst && fs) strobes++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (gci=%0d wide=%0d inv=%0d)",
               req, act, exp, gci, wide, inv);
    end
  endtask

  // Slot = 8 system clocks; reference edge at slot position 4,
  // pulse changes at position 0 (opposite edge).
  task automatic play(input bit g, input bit w, input bit i, input int nfr,
                      input int skip, input int bad, input int badlen);
    int nl, exp_str;
    nl = w ? 2 : 1;
    rst = 1'b1; gci = g; wide = w; inv = i;
    bus_clk = i; fp = ~g;
    repeat (4) @(negedge clk);
    check(fs == 1'b0 && cnt == '0 && err == 1'b0, "R1 reset outputs",
          int'({fs, cnt, err}), 0);
    rst = 1'b0;
    strobes = 0;
    for (int s = 0; s <= nfr * F; s++) begin
      int f, k;
      bit act, exp_err;
      f = s / F;
      k = s % F;
      act = 1'b0;
      // R2 active level per convention, R4 pulse spans nl slots
      if (f < nfr && f != skip && k >= F - nl) act = 1'b1;
      if (f == bad && k >= F/2 - badlen && k < F/2) act = 1'b1;
      exp_err = (bad >= 0) && (s >= bad * F + F/2);
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        if (p == 5) begin
          if (s >= F) check(int'(cnt) == k, "R3 bit count phase", int'(cnt), k);
          check(err == exp_err, "R6 width error flag", int'(err), int'(exp_err));
        end
        bus_clk = (p >= 4) ^ i;
        fp = act ? g : ~g;
      end
    end
    repeat (4) @(negedge clk);
    exp_str = nfr - ((skip >= 0 && skip < nfr) ? 1 : 0);
    check(strobes == exp_str, "R2 R4 R5 strobe count", strobes, exp_str);
  endtask

  initial begin
    // full sweep of convention, width and polarity
    for (int g = 0; g < 2; g++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 2; i++)
          play(g[0], w[0], i[0], 3, -1, -1, 0);
    // R6 mismatched pulses placed off-phase
    play(1'b0, 1'b0, 1'b1, 3, -1, 1, 2);
    play(1'b1, 1'b1, 1'b0, 3, -1, 1, 1);
    play(1'b1, 1'b1, 1'b1, 3, -1, 1, 3);
    play(1'b0, 1'b0, 1'b0, 3, -1, 1, 2);
    // R3 free-running wrap with a missing pulse
    play(1'b0, 1'b1, 1'b0, 3, 1, -1, 0);
    play(1'b1, 1'b0, 1'b1, 3, 1, -1, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule